// File: doc/BRIEF.md
# Dual Accumulator Saturating Adder

This block is the accumulate stage of a fixed-point datapath. It holds two 40-bit accumulators, A and B, each in 9.31 form: eight guard bits above a 1.31 fraction. Every valid operation reads one accumulator, or a forced zero for a load, and adds or subtracts a 40-bit operand. The result goes into the accumulator named by a separate destination select. For add and load, a signed shift count first scales the operand through a barrel shifter.

The adder result is checked for two kinds of overflow. The first is a recoverable spill into the guard bits. The second is a catastrophic carry out of bit 39, which destroys the sign. If saturation is enabled for the destination accumulator, the result is clamped to the 1.31 limits or the 9.31 limits, chosen by a mode input. Each accumulator has its own overflow flag, which describes the latest write to it, and its own sticky saturation flag. OR summaries of both flag pairs and per-accumulator trap requests are also provided.

Top module: `dual_acc_sat_adder`

## Requirements
- R1: With `op_valid` high and `op_code` = 2'b00 (add), the destination gets source accumulator + shifted operand on the next clock edge. Without saturation the result wraps modulo 2^40.
- R2: With `op_code` = 2'b01 (subtract), the destination gets source accumulator − operand. The shift count has no effect on a subtract.
- R3: With `op_code[1]` = 1 (load), the destination gets the shifted operand. The source accumulator has no effect.
- R4: `shift_cnt` is a 5-bit two's-complement count. A value 0..15 shifts the operand right arithmetically by that amount. A value −1..−16 shifts it left by the magnitude, and bits shifted past bit 39 are lost.
- R5: `src_sel` and `dst_sel` pick accumulators independently, where 0 means A and 1 means B. The other accumulator and its overflow flag do not change. When `op_valid` is low, neither accumulator and neither overflow flag changes.
- R6: On each write, the destination's overflow flag (`ovf_a`/`ovf_b`) is loaded with 1 when bits 39..32 of the unsaturated adder result are not all equal, and with 0 otherwise.
- R7: When the destination's saturation enable is high and `sat_wide` = 0, a true result above 2^31−1 stores 0x007FFFFFFF and a true result below −2^31 stores 0xFF80000000.
- R8: When the destination's saturation enable is high and `sat_wide` = 1, a true result above 2^39−1 stores 0x7FFFFFFFFF and a true result below −2^39 stores 0x8000000000.
- R9: The destination's sticky flag (`sat_a`/`sat_b`) is set when the true result falls outside the 40-bit range or when saturation clamps the result. `sticky_clr` clears both sticky flags, but a set in the same cycle wins.
- R10: `ovf_any` is `ovf_a` OR `ovf_b`, and `sat_any` is `sat_a` OR `sat_b`.
- R11: `trap_a` is high exactly when `ovf_a` and `trap_en_a` are both high. `trap_b` follows the same rule with `ovf_b` and `trap_en_b`.
- R12: While `rst_n` is low, both accumulators and all flags go to zero on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Perform an operation this cycle |
| op_code | input | 2 | 00 add, 01 subtract, 1x load |
| src_sel | input | 1 | Source accumulator (0 A, 1 B) |
| dst_sel | input | 1 | Destination accumulator (0 A, 1 B) |
| operand | input | 40 | Operand, two's complement |
| shift_cnt | input | 5 | Signed scale count for add/load |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_wide | input | 1 | 0: 1.31 limits, 1: 9.31 limits |
| trap_en_a | input | 1 | Trap enable for A |
| trap_en_b | input | 1 | Trap enable for B |
| sticky_clr | input | 1 | Clear both sticky saturation flags |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | Guard overflow of latest write to A |
| ovf_b | output | 1 | Guard overflow of latest write to B |
| ovf_any | output | 1 | OR of the overflow flags |
| sat_a | output | 1 | Sticky saturation/overflow flag of A |
| sat_b | output | 1 | Sticky saturation/overflow flag of B |
| sat_any | output | 1 | OR of the sticky flags |
| trap_a | output | 1 | Arithmetic warning request for A |
| trap_b | output | 1 | Arithmetic warning request for B |

## Verification
Each operation's effect on the accumulators, the overflow flags and the sticky flags appears after exactly one clock edge. The bench applies inputs on a falling edge and compares on the following falling edge, so one rising edge falls between drive and check. The summaries and trap requests are combinational from those registers and the trap enables. They are checked in the same sample while the enables are still held. A bench model in 64-bit arithmetic tracks both accumulators across a sweep of every shift count, each operation, six operands and three saturation settings.

// File: rtl/dacc_pkg.sv
// Shared constants for the dual accumulator adder.
// Assumes: the opcode encoding below is fixed by the block's port contract.
package dacc_pkg;
    localparam logic [1:0] OP_ADD = 2'b00;
    localparam logic [1:0] OP_SUB = 2'b01;
    // Any code with bit 1 set is a load.
endpackage

// File: rtl/dacc_shifter.sv
// Barrel scaler for the incoming operand.
// Assumes: cnt is two's complement; non-negative shifts right arithmetically,
// negative shifts left by the magnitude, dropping bits above W-1.
module dacc_shifter #(
    parameter int W  = 40,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] cnt,
    output logic [W-1:0]  dout
);
    logic [SW-1:0] mag;

    // Select shift direction from the count's sign bit.
    always_comb begin
        mag = '0 - cnt;
        if (cnt[SW-1]) dout = din << mag;
        else           dout = $signed(din) >>> cnt;
    end
endmodule

// File: rtl/dacc_addsat.sv
// 40-bit adder/subtracter with guard-bit and sign overflow detection and
// optional clamping to 1.31 or 9.31 limits.
// Assumes: subtract complements the operand and forces carry-in high.
module dacc_addsat #(
    parameter int W = 40,
    parameter int G = 8
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] opnd,
    input  logic         zero_src,
    input  logic         subtract,
    input  logic         sat_en,
    input  logic         sat_wide,
    output logic [W-1:0] result,
    output logic         guard_ovf,
    output logic         sign_ovf,
    output logic         sat_hit
);
    localparam int NB = W - G - 1;   // top index of the narrow fraction range

    logic [W-1:0] a_in, b_in, raw;
    logic [W:0]   sum_x;
    logic         narrow_ovf, true_neg;

    // Extended-precision add with complement-and-carry subtraction.
    always_comb begin
        a_in  = zero_src ? '0 : src;
        b_in  = subtract ? ~opnd : opnd;
        sum_x = {a_in[W-1], a_in} + {b_in[W-1], b_in} + {{W{1'b0}}, subtract};
        raw   = sum_x[W-1:0];
        true_neg   = sum_x[W];
        sign_ovf   = sum_x[W] ^ sum_x[W-1];
        guard_ovf  = !((&raw[W-1:W-G]) || !(|raw[W-1:W-G]));
        narrow_ovf = !((&raw[W-1:NB]) || !(|raw[W-1:NB]));
    end

    // Decide on clamping and pick the limit by true sign and mode.
    always_comb begin
        sat_hit = sat_en && (sign_ovf || (!sat_wide && narrow_ovf));
        result  = raw;
        if (sat_hit) begin
            if (sat_wide) result = true_neg ? {1'b1, {(W-1){1'b0}}}
                                            : {1'b0, {(W-1){1'b1}}};
            else          result = true_neg ? {{(G+1){1'b1}}, {NB{1'b0}}}
                                            : {{(G+1){1'b0}}, {NB{1'b1}}};
        end
    end
endmodule

// File: rtl/dacc_lane.sv
// One accumulator with its overflow flag and sticky saturation flag.
// Assumes: wr is already qualified by op_valid and destination select.
module dacc_lane #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] res,
    input  logic         gov,
    input  logic         sat_set,
    input  logic         clr,
    output logic [W-1:0] acc,
    output logic         ovf,
    output logic         sat
);
    // Register the accumulator and overflow flag on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (wr) begin
            acc <= res;
            ovf <= gov;
        end
    end

    // Sticky flag: clear on request, set wins in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)              sat <= 1'b0;
        else if (wr && sat_set)  sat <= 1'b1;
        else if (clr)            sat <= 1'b0;
    end
endmodule

// File: rtl/dual_acc_sat_adder.sv
// Top: two 9.31 accumulators sharing one scaler and one adder/saturator.
// Assumes: one operation per cycle; results register on the next edge;
// summaries and trap requests are combinational from the registered flags.
module dual_acc_sat_adder
    import dacc_pkg::*;
#(
    parameter int W  = 40,
    parameter int G  = 8,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_code,
    input  logic          src_sel,
    input  logic          dst_sel,
    input  logic [W-1:0]  operand,
    input  logic [SW-1:0] shift_cnt,
    input  logic          sat_en_a,
    input  logic          sat_en_b,
    input  logic          sat_wide,
    input  logic          trap_en_a,
    input  logic          trap_en_b,
    input  logic          sticky_clr,
    output logic [W-1:0]  acc_a,
    output logic [W-1:0]  acc_b,
    output logic          ovf_a,
    output logic          ovf_b,
    output logic          ovf_any,
    output logic          sat_a,
    output logic          sat_b,
    output logic          sat_any,
    output logic          trap_a,
    output logic          trap_b
);
    localparam int NACC = 2;

    logic [NACC-1:0][W-1:0] acc_q;
    logic [NACC-1:0]        ovf_q, sat_q, sat_en_v, trap_en_v;
    logic [W-1:0]           scaled, addend, src_val, res;
    logic                   is_sub, is_load, sel_sat_en;
    logic                   gov, sov, shit;

    // Decode the operation and route operands.
    always_comb begin
        is_sub     = (op_code == OP_SUB);
        is_load    = op_code[1];
        sat_en_v   = {sat_en_b, sat_en_a};
        trap_en_v  = {trap_en_b, trap_en_a};
        src_val    = acc_q[src_sel];
        addend     = is_sub ? operand : scaled;
        sel_sat_en = sat_en_v[dst_sel];
    end

    dacc_shifter #(.W(W), .SW(SW)) u_shift (
        .din(operand), .cnt(shift_cnt), .dout(scaled)
    );

    dacc_addsat #(.W(W), .G(G)) u_add (
        .src(src_val), .opnd(addend), .zero_src(is_load), .subtract(is_sub),
        .sat_en(sel_sat_en), .sat_wide(sat_wide), .result(res),
        .guard_ovf(gov), .sign_ovf(sov), .sat_hit(shit)
    );

    for (genvar i = 0; i < NACC; i++) begin : g_lane
        dacc_lane #(.W(W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .wr(op_valid && (dst_sel == 1'(i))),
            .res(res), .gov(gov), .sat_set(sov || shit), .clr(sticky_clr),
            .acc(acc_q[i]), .ovf(ovf_q[i]), .sat(sat_q[i])
        );
    end

    // Present per-accumulator state, summaries and trap requests.
    always_comb begin
        acc_a   = acc_q[0];
        acc_b   = acc_q[1];
        ovf_a   = ovf_q[0];
        ovf_b   = ovf_q[1];
        sat_a   = sat_q[0];
        sat_b   = sat_q[1];
        ovf_any = |ovf_q;
        sat_any = |sat_q;
        trap_a  = ovf_q[0] && trap_en_v[0];
        trap_b  = ovf_q[1] && trap_en_v[1];
    end
endmodule

// File: rtl/dacc_checker.sv
// Temporal checks on the dual accumulator adder, bound into every instance.
module dacc_checker #(
    parameter int W = 40,
    parameter int G = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic         dst_sel,
    input logic         sat_en_a,
    input logic         sat_wide,
    input logic         trap_en_a,
    input logic         sticky_clr,
    input logic [W-1:0] acc_a,
    input logic [W-1:0] acc_b,
    input logic         ovf_a,
    input logic         sat_a,
    input logic         sat_b,
    input logic         trap_a
);
    // R5: idle cycle leaves both accumulators alone.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b)));

    // R5: a write to A leaves B alone.
    a_r5_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dst_sel) |=> $stable(acc_b));

    // R6: A's overflow flag moves only on a write to A.
    a_r6_ovf_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && !dst_sel) |=> $stable(ovf_a));

    // R7: narrow saturation keeps A inside the 1.31 range.
    a_r7_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dst_sel && sat_en_a && !sat_wide) |=>
        ($countones(acc_a[W-1:W-G-1]) == 0 || $countones(acc_a[W-1:W-G-1]) == G + 1));

    // R9: sticky flag survives without a clear.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_a && !sticky_clr) |=> sat_a);

    // R9: clear with no operation drops both sticky flags.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_clr && !op_valid) |=> (!sat_a && !sat_b));

    // R9: A's sticky flag rises only after a write to A.
    a_r9_rise_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && !dst_sel) |=> !$rose(sat_a));

    // R11: no trap request without its enable.
    a_r11_trap_gated: assert property (@(posedge clk) disable iff (!rst_n)
        trap_a |-> trap_en_a);
endmodule

bind dual_acc_sat_adder dacc_checker #(.W(W), .G(G)) u_chk (.*);

// File: tb/sim_dual_acc_sat_adder.sv
`timescale 1ns/1ps
module sim_dual_acc_sat_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic        src_sel = 1'b0, dst_sel = 1'b0;
    logic [39:0] operand = '0;
    logic [4:0]  shift_cnt = '0;
    logic        sat_en_a = 1'b0, sat_en_b = 1'b0, sat_wide = 1'b0;
    logic        trap_en_a = 1'b0, trap_en_b = 1'b0, sticky_clr = 1'b0;
    logic [39:0] acc_a, acc_b;
    logic        ovf_a, ovf_b, ovf_any, sat_a, sat_b, sat_any, trap_a, trap_b;

    int checks = 0;
    int errors = 0;

    logic [39:0] m_acc [2];
    bit          m_ovf [2];
    bit          m_sat [2];

    always #2.5 clk = ~clk;

    dual_acc_sat_adder u0 (.*);

    function automatic longint sx40(input logic [39:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [39:0] lo40(input longint v);
        logic [63:0] t;
        t = v;
        return t[39:0];
    endfunction

    function automatic logic [39:0] opnd_of(input int k);
        case (k)
            0: return 40'h00_0000_1234;
            1: return 40'h00_4000_0000;
            2: return 40'hFF_C000_0000;
            3: return 40'h7F_0000_0000;
            4: return 40'h80_0000_0001;
            default: return 40'h00_0000_0001;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model; tag names the accumulator rule.
    task automatic check_all(input string tag);
        chk(acc_a == m_acc[0], tag, "acc_a", 64'(acc_a), 64'(m_acc[0]));
        chk(acc_b == m_acc[1], tag, "acc_b", 64'(acc_b), 64'(m_acc[1]));
        chk({ovf_b, ovf_a} == {m_ovf[1], m_ovf[0]}, "R6", "ovf_b/ovf_a",
            64'({ovf_b, ovf_a}), 64'({m_ovf[1], m_ovf[0]}));
        chk({sat_b, sat_a} == {m_sat[1], m_sat[0]}, "R9", "sat_b/sat_a",
            64'({sat_b, sat_a}), 64'({m_sat[1], m_sat[0]}));
        chk({ovf_any, sat_any} == {m_ovf[0] | m_ovf[1], m_sat[0] | m_sat[1]}, "R10",
            "ovf_any/sat_any", 64'({ovf_any, sat_any}),
            64'({m_ovf[0] | m_ovf[1], m_sat[0] | m_sat[1]}));
        chk({trap_b, trap_a} == {m_ovf[1] & trap_en_b, m_ovf[0] & trap_en_a}, "R11",
            "trap_b/trap_a", 64'({trap_b, trap_a}),
            64'({m_ovf[1] & trap_en_b, m_ovf[0] & trap_en_a}));
    endtask

    // Arithmetic model of one operation (R1..R4, R6..R9); returns the rule tag.
    task automatic model_op(input int op, input int s, input bit clr, output string tag);
        longint src, sh, sum;
        longint nmax, nmin, wmax, wmin;
        logic [63:0] tl;
        logic [39:0] wrapped;
        logic [7:0]  g;
        bit se, ovf39, hit;
        int d;
        d    = dst_sel;
        nmax = 64'sh7FFF_FFFF;        nmin = -64'sh8000_0000;
        wmax = 64'sh7F_FFFF_FFFF;     wmin = -64'sh80_0000_0000;
        src  = sx40(m_acc[src_sel]);
        // R4: positive count shifts right arithmetically, negative shifts left.
        if (s >= 0) sh = sx40(operand) >>> s;
        else begin
            tl = sx40(operand) << (-s);
            sh = sx40(tl[39:0]);
        end
        if (op == 1)      begin sum = src - sx40(operand); tag = "R2"; end
        else if (op == 0) begin sum = src + sh;            tag = (s != 0) ? "R4" : "R1"; end
        else              begin sum = sh;                  tag = (s != 0) ? "R4" : "R3"; end
        ovf39   = (sum > wmax) || (sum < wmin);
        wrapped = lo40(sum);
        g       = wrapped[39:32];
        se      = d ? sat_en_b : sat_en_a;
        hit     = 1'b0;
        if (se && sat_wide && ovf39) begin
            hit = 1'b1; tag = "R8";
            wrapped = (sum < 0) ? 40'h80_0000_0000 : 40'h7F_FFFF_FFFF;
        end else if (se && !sat_wide && (sum > nmax || sum < nmin)) begin
            hit = 1'b1; tag = "R7";
            wrapped = (sum < 0) ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF;
        end
        m_acc[d] = wrapped;
        m_ovf[d] = !(g == 8'h00 || g == 8'hFF);
        if (clr) begin m_sat[0] = 1'b0; m_sat[1] = 1'b0; end
        if (ovf39 || hit) m_sat[d] = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        string tag;
        int n;
        n = 0;
        for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ovf[i] = 0; m_sat[i] = 0; end
        // R12: reset clears everything.
        repeat (3) @(negedge clk);
        check_all("R12");
        rst_n = 1'b1;
        for (int cfg = 0; cfg < 3; cfg++) begin
            for (int s = -16; s <= 15; s++) begin
                for (int k = 0; k < 6; k++) begin
                    for (int op = 0; op < 3; op++) begin
                        op_valid   = 1'b1;
                        op_code    = (op == 2) ? 2'(2 + (k & 1)) : 2'(op);
                        src_sel    = k[0];
                        dst_sel    = k[1] ^ op[0];
                        operand    = opnd_of(k);
                        shift_cnt  = 5'(s);
                        sat_en_a   = (cfg != 0);
                        sat_en_b   = (cfg != 0) && !s[0];   // separate enables
                        sat_wide   = (cfg == 2);
                        trap_en_a  = k[0];
                        trap_en_b  = !k[0];
                        sticky_clr = ((n % 7) == 0);
                        model_op(op, s, sticky_clr, tag);
                        n++;
                        @(negedge clk);
                        check_all(tag);
                    end
                end
                // R5: an idle cycle with a new operand changes nothing.
                op_valid   = 1'b0;
                sticky_clr = 1'b0;
                operand    = 40'h7F_FFFF_FFFF;
                @(negedge clk);
                check_all("R5");
            end
            // R9: a clear with no operation empties both sticky flags.
            op_valid   = 1'b0;
            sticky_clr = 1'b1;
            m_sat[0] = 1'b0; m_sat[1] = 1'b0;
            @(negedge clk);
            check_all("R9");
            sticky_clr = 1'b0;
        end
        // R12: reset mid-run returns to zero.
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ovf[i] = 0; m_sat[i] = 0; end
        @(negedge clk);
        check_all("R12");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule